// File: doc/BRIEF.md
# CAN Acceptance Filter Bank

This block sits after a CAN receiver and decides whether a frame that has been fully received should be kept. Each frame is presented as a descriptor: the identifier, the extended-format flag, and the first two payload bytes, qualified by a single-cycle valid strobe. The descriptor is compared against a bank of programmable filter/mask pairs. One clock later the block raises an accept pulse and reports which filter won.

Masks choose which bits take part in the compare, so one pair can select on the identifier, on payload content, on frame format, or on any mix of these. A global enable input switches the bank off, and while it is off every frame is accepted. Filter and mask contents can be loaded only while the initialization-mode input is high. A reset does not clear them, so a configuration stays in place across a reset.

Top module: `can_accept_filter`

## Requirements
- R1: Each entry compares a 46-bit frame key laid out as bit 45 = extended flag, bits 44:16 = identifier, bits 15:8 = payload byte 0, bits 7:0 = payload byte 1. Where a mask bit is 1, the key bit must equal the filter bit. Where a mask bit is 0, that key bit plays no part. An all-zero mask therefore matches every frame.
- R2: For a standard-format frame (extended flag 0), the 11-bit identifier is carried in identifier bits 28:18. Identifier bits 17:0 are compared as zeros, whatever value is on the input.
- R3: The extended flag (key bit 45) is compared like any other key bit, under mask control.
- R4: While the global enable is low, every valid frame is accepted, and the reported index is 0.
- R5: While the global enable is high and several entries match, the index reported is the lowest-numbered matching entry.
- R6: While the global enable is high and no entry matches, no accept pulse is produced.
- R7: A register write takes effect only while the initialization-mode input is high. Writes at any other time leave every filter and mask unchanged. The write select is 0 for a filter and 1 for a mask.
- R8: Filter and mask contents are not changed by reset. Frames after a reset are judged against the values loaded before it.
- R9: The accept pulse and index appear exactly one clock after the cycle in which the frame strobe is sampled. Back-to-back frames give back-to-back results. The index reads 0 in any cycle without an accept pulse.
- R10: While reset is asserted, and on the first cycle after it, the accept pulse and the index are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (outputs only) |
| init_mode | input | 1 | High while configuration writes are permitted |
| filt_en | input | 1 | Global filtering enable |
| wr_en | input | 1 | Register write strobe |
| wr_mask | input | 1 | Write target: 0 filter, 1 mask |
| wr_idx | input | 3 | Entry number being written |
| wr_data | input | 46 | Key-formatted value to store |
| frm_vld | input | 1 | Frame descriptor valid, one cycle per frame |
| frm_ext | input | 1 | Extended-format flag |
| frm_id | input | 29 | Identifier (standard IDs in bits 28:18) |
| frm_b0 | input | 8 | Payload byte 0 |
| frm_b1 | input | 8 | Payload byte 1 |
| acc_pulse | output | 1 | Frame accepted, one cycle |
| acc_idx | output | 3 | Winning entry, 0 when filtering is off or nothing is accepted |

## Verification
The assertions assume that configuration writes and frame descriptors are never mixed with reset in a way that matters to the outputs. They also assume that filtering is enabled only after all eight entries hold defined values, because unwritten storage has no reset value. The stimulus keeps to this by loading every filter and mask under initialization mode before it raises the enable. It lets the pipeline drain before each reset, and it issues frames only in cycles the reference model can attribute to a single descriptor. Back-to-back strobes are used on purpose to exercise the one-cycle result timing.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

    localparam int NUM_FLT = 8;
    localparam int ID_W    = 29;
    localparam int STD_W   = 11;
    localparam int BYTE_W  = 8;
    localparam int KEY_W   = 1 + ID_W + 2 * BYTE_W;

    typedef logic [KEY_W-1:0] key_t;

    // Packed order gives the key layout: ext, id, byte0, byte1
    typedef struct packed {
        logic              ext;
        logic [ID_W-1:0]   id;
        logic [BYTE_W-1:0] b0;
        logic [BYTE_W-1:0] b1;
    } frame_t;

    typedef enum logic {
        SEL_FILTER = 1'b0,
        SEL_MASK   = 1'b1
    } wsel_e;

    // Standard frames: identifier bits below the 11-bit field read as zero
    function automatic key_t make_key(frame_t f);
        frame_t k;
        k = f;
        if (!f.ext) k.id[ID_W-STD_W-1:0] = '0;
        return key_t'(k);
    endfunction

    function automatic logic key_hit(key_t frm, key_t flt, key_t msk);
        return ((frm ^ flt) & msk) == '0;
    endfunction

endpackage

// File: rtl/can_flt_regs.sv
module can_flt_regs
    import can_flt_pkg::*;
#(
    parameter int NUM = NUM_FLT,
    parameter int IW  = $clog2(NUM)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      init_mode,
    input  logic                      wr_en,
    input  logic                      wr_mask,
    input  logic [IW-1:0]             wr_idx,
    input  logic [KEY_W-1:0]          wr_data,
    output logic [NUM-1:0][KEY_W-1:0] flt_q,
    output logic [NUM-1:0][KEY_W-1:0] msk_q
);

    // No reset on storage: contents persist across reset
    always_ff @(posedge clk) begin
        if (init_mode && wr_en) begin
            if (wsel_e'(wr_mask) == SEL_MASK) msk_q[wr_idx] <= wr_data;
            else                              flt_q[wr_idx] <= wr_data;
        end
    end

    AST_WR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        !init_mode |=> ($stable(flt_q) && $stable(msk_q)));  // R7

    AST_FLT_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (init_mode && wr_en && !wr_mask) |=> flt_q[$past(wr_idx)] == $past(wr_data));  // R7

    AST_MSK_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (init_mode && wr_en && wr_mask) |=> msk_q[$past(wr_idx)] == $past(wr_data));  // R7

endmodule

// File: rtl/can_flt_match.sv
module can_flt_match
    import can_flt_pkg::*;
#(
    parameter int NUM = NUM_FLT
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [KEY_W-1:0]          key_i,
    input  logic [NUM-1:0][KEY_W-1:0] flt_i,
    input  logic [NUM-1:0][KEY_W-1:0] msk_i,
    output logic [NUM-1:0]            hit_o
);

    for (genvar g = 0; g < NUM; g++) begin : g_entry
        assign hit_o[g] = key_hit(key_i, flt_i[g], msk_i[g]);

        AST_OPEN_MASK_HITS: assert property (@(posedge clk) disable iff (rst)
            (msk_i[g] == '0) |-> hit_o[g]);  // R1
    end

endmodule

// File: rtl/can_flt_prio.sv
module can_flt_prio #(
    parameter int NUM = 8,
    parameter int IW  = $clog2(NUM)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NUM-1:0] hit_i,
    output logic           found_o,
    output logic [IW-1:0]  idx_o
);

    // Scan downward so the lowest set bit is the last one written
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM - 1; i >= 0; i--) begin
            if (hit_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        found_o |-> (hit_i[idx_o] && ((hit_i & ~({NUM{1'b1}} << idx_o)) == '0)));  // R5

    AST_NONE_FOUND: assert property (@(posedge clk) disable iff (rst)
        (hit_i == '0) |-> !found_o);  // R6

endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_flt_pkg::*;
#(
    parameter int  NUM_FLT_P = NUM_FLT,
    localparam int IDX_W     = $clog2(NUM_FLT_P)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_mode,
    input  logic               filt_en,
    input  logic               wr_en,
    input  logic               wr_mask,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [KEY_W-1:0]   wr_data,
    input  logic               frm_vld,
    input  logic               frm_ext,
    input  logic [ID_W-1:0]    frm_id,
    input  logic [BYTE_W-1:0]  frm_b0,
    input  logic [BYTE_W-1:0]  frm_b1,
    output logic               acc_pulse,
    output logic [IDX_W-1:0]   acc_idx
);

    frame_t                          frm;
    key_t                            key;
    logic [NUM_FLT_P-1:0][KEY_W-1:0] flt_q;
    logic [NUM_FLT_P-1:0][KEY_W-1:0] msk_q;
    logic [NUM_FLT_P-1:0]            hit;
    logic                            found;
    logic [IDX_W-1:0]                win;

    assign frm = '{ext: frm_ext, id: frm_id, b0: frm_b0, b1: frm_b1};
    assign key = make_key(frm);

    can_flt_regs #(.NUM(NUM_FLT_P), .IW(IDX_W)) u_regs (
        .clk(clk), .rst(rst), .init_mode(init_mode), .wr_en(wr_en),
        .wr_mask(wr_mask), .wr_idx(wr_idx), .wr_data(wr_data),
        .flt_q(flt_q), .msk_q(msk_q)
    );

    can_flt_match #(.NUM(NUM_FLT_P)) u_match (
        .clk(clk), .rst(rst), .key_i(key), .flt_i(flt_q), .msk_i(msk_q), .hit_o(hit)
    );

    can_flt_prio #(.NUM(NUM_FLT_P), .IW(IDX_W)) u_prio (
        .clk(clk), .rst(rst), .hit_i(hit), .found_o(found), .idx_o(win)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_pulse <= 1'b0;
            acc_idx   <= '0;
        end else begin
            acc_pulse <= frm_vld && (!filt_en || found);
            acc_idx   <= (frm_vld && filt_en && found) ? win : '0;
        end
    end

    AST_PULSE_NEEDS_FRAME: assert property (@(posedge clk) disable iff (rst)
        acc_pulse |-> $past(frm_vld));  // R9

    AST_IDX_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_pulse |-> (acc_idx == '0));  // R9

    AST_OFF_ACCEPTS_ALL: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && !filt_en) |=> (acc_pulse && acc_idx == '0));  // R4

    AST_NO_HIT_DROPS: assert property (@(posedge clk) disable iff (rst)
        (frm_vld && filt_en && hit == '0) |=> !acc_pulse);  // R6

endmodule

// File: tb/can_accept_filter_test.sv
module can_accept_filter_test;

    localparam int KW = 46;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_mode = 1'b0;
    logic        filt_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_mask = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [KW-1:0] wr_data = '0;
    logic        frm_vld = 1'b0;
    logic        frm_ext = 1'b0;
    logic [28:0] frm_id = '0;
    logic [7:0]  frm_b0 = '0;
    logic [7:0]  frm_b1 = '0;
    logic        acc_pulse;
    logic [2:0]  acc_idx;

    always #4 clk = ~clk;  // 125 MHz

    can_accept_filter uut (
        .clk(clk), .rst(rst), .init_mode(init_mode), .filt_en(filt_en),
        .wr_en(wr_en), .wr_mask(wr_mask), .wr_idx(wr_idx), .wr_data(wr_data),
        .frm_vld(frm_vld), .frm_ext(frm_ext), .frm_id(frm_id),
        .frm_b0(frm_b0), .frm_b1(frm_b1), .acc_pulse(acc_pulse), .acc_idx(acc_idx)
    );

    typedef struct {
        logic       acc;
        logic [2:0] idx;
        string      req;
    } exp_t;

    exp_t          sb[$];
    logic [KW-1:0] m_flt [8];
    logic [KW-1:0] m_msk [8];
    int            checks = 0;
    int            errors = 0;
    logic          pend = 1'b0;
    logic          done = 1'b0;

    function automatic logic [KW-1:0] bkey(logic ext, logic [28:0] id, logic [7:0] b0, logic [7:0] b1);
        return {ext, ext ? id : {id[28:18], 18'h0}, b0, b1};
    endfunction

    task automatic chk(logic ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic write_reg(logic msk, logic [2:0] idx, logic [KW-1:0] d);
        wr_en = 1'b1; wr_mask = msk; wr_idx = idx; wr_data = d;
        if (init_mode) begin
            if (msk) m_msk[idx] = d; else m_flt[idx] = d;
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: leaves frm_vld high so consecutive calls are back to back
    task automatic send(logic ext, logic [28:0] id, logic [7:0] b0, logic [7:0] b1, string req);
        exp_t e;
        logic [KW-1:0] k;
        k = bkey(ext, id, b0, b1);
        e.req = req; e.acc = 1'b0; e.idx = 3'd0;
        if (!filt_en) e.acc = 1'b1;
        else begin
            for (int i = 7; i >= 0; i--) begin
                if (((k ^ m_flt[i]) & m_msk[i]) == '0) begin
                    e.acc = 1'b1; e.idx = 3'(i);
                end
            end
        end
        sb.push_back(e);
        frm_vld = 1'b1; frm_ext = ext; frm_id = id; frm_b0 = b0; frm_b1 = b1;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        frm_vld = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) pend <= frm_vld;

    // Monitor: results are due one clock after the strobe is sampled (R9)
    always @(negedge clk) begin
        if (pend) begin
            exp_t e;
            if (sb.size() == 0) chk(1'b0, "R9 unexpected result", int'(acc_pulse), 0);
            else begin
                e = sb.pop_front();
                chk(acc_pulse === e.acc, {e.req, " accept"}, int'(acc_pulse), int'(e.acc));
                chk(acc_idx === e.idx, {e.req, " index"}, int'(acc_idx), int'(e.idx));
            end
        end else if (!rst) begin
            if (acc_pulse !== 1'b0) chk(1'b0, "R9 spurious pulse", int'(acc_pulse), 0);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(acc_pulse === 1'b0, "R10 reset pulse", int'(acc_pulse), 0);
        chk(acc_idx === 3'd0, "R10 reset index", int'(acc_idx), 0);
        rst = 1'b0;
        @(negedge clk);

        // Filtering off: everything accepted at index 0
        send(1'b1, 29'h0ABCDEF, 8'h11, 8'h22, "R4 off ext");
        send(1'b0, 29'h1555555, 8'h00, 8'hFF, "R4 off std");
        idle(2);

        init_mode = 1'b1;
        write_reg(1'b0, 3'd0, bkey(1'b1, 29'h1ABCDEF0, 8'h00, 8'h00));
        write_reg(1'b1, 3'd0, {1'b1, {29{1'b1}}, 16'h0});
        write_reg(1'b0, 3'd1, bkey(1'b0, {11'h123, 18'h0}, 8'h00, 8'h00));
        write_reg(1'b1, 3'd1, {1'b1, {29{1'b1}}, 16'h0});
        write_reg(1'b0, 3'd2, {30'h0, 8'h55, 8'h00});
        write_reg(1'b1, 3'd2, {30'h0, 8'hFF, 8'h00});
        write_reg(1'b0, 3'd3, {1'b1, 29'h0, 8'h00, 8'hAA});
        write_reg(1'b1, 3'd3, {1'b1, 29'h0, 8'h00, 8'hFF});
        for (int i = 4; i < 7; i++) begin
            write_reg(1'b0, 3'(i), {KW{1'b1}});
            write_reg(1'b1, 3'(i), {KW{1'b1}});
        end
        write_reg(1'b0, 3'd7, '0);
        write_reg(1'b1, 3'd7, '0);
        init_mode = 1'b0;
        filt_en = 1'b1;
        @(negedge clk);

        send(1'b1, 29'h1ABCDEF0, 8'h00, 8'h00, "R1 id match");
        send(1'b1, 29'h1ABCDEF0, 8'h55, 8'h00, "R5 lowest of 0,2,7");
        send(1'b1, 29'h1ABCDEF1, 8'h55, 8'h00, "R1 byte0 match");
        send(1'b0, {11'h123, 18'h2AAAA}, 8'h00, 8'h00, "R2 std low bits ignored");
        send(1'b1, {11'h123, 18'h0}, 8'h00, 8'hAA, "R3 ext flag differs");
        send(1'b0, 29'h5, 8'h00, 8'hAA, "R3 std misses ext entry");
        idle(2);

        // Write outside init mode must be ignored
        write_reg(1'b0, 3'd0, '0);
        write_reg(1'b1, 3'd7, {KW{1'b1}});
        send(1'b1, 29'h1ABCDEF0, 8'h00, 8'h00, "R7 locked write");
        send(1'b0, 29'h5, 8'h00, 8'h01, "R7 catch-all kept");
        idle(2);

        rst = 1'b1;
        @(negedge clk);
        chk(acc_pulse === 1'b0, "R10 mid reset pulse", int'(acc_pulse), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        send(1'b1, 29'h1ABCDEF0, 8'h00, 8'h00, "R8 entry0 kept");
        send(1'b0, {11'h123, 18'h3FFFF}, 8'h00, 8'h00, "R8 entry1 kept");
        idle(2);

        init_mode = 1'b1;
        write_reg(1'b1, 3'd7, {KW{1'b1}});
        init_mode = 1'b0;
        send(1'b0, 29'h5, 8'h00, 8'hAA, "R6 no match");
        send(1'b0, 29'h0, 8'h00, 8'h00, "R7 init write took");
        idle(1);
        filt_en = 1'b0;
        send(1'b0, 29'h5, 8'h00, 8'hAA, "R4 off again");
        idle(3);

        chk(sb.size() == 0, "R9 all results seen", sb.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule